// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the software-visible control and status register file of a multi-channel DMA engine. A 32-bit register port with a byte offset reaches a few global registers and one shared window of per-channel registers. A channel-select register decides which of the channel banks that window reaches. Each bank holds a control word, a descriptor base address, a descriptor count, an interrupt status word and an interrupt enable word. Port configuration works the same way: a port-select register picks which port-control word the port-control offset reaches.

Each channel has a self-clearing reset. Software sets it and then polls until it reads back as zero. A global reset returns the whole file to its reset state. Descriptor completion is represented by one stub input per channel, which raises a status cause. A global per-channel enable mask folds all unmasked, enabled causes into a single interrupt line. The descriptor fetcher and the data movers sit outside this block. The register port is plain: a write strobe with address and data, and read data that always reflects the current address.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, every mapped offset reads 0 and `irq` is low.
- R2: Writing a channel number below NCH (20) to the select offset 0x18 makes offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C read and write that channel's bank only. The select offset reads back the stored number, which is 5 bits wide.
- R3: While the stored select value is NCH or above, the banked offsets read 0 and writes to them change no bank.
- R4: Field storage works as follows:
  - Channel control (0x1C) keeps bit 0 (channel on), bit 8 (transmit direction) and bits 17:16 (arbitration weight).
  - Descriptor base (0x20) keeps all 32 bits.
  - Descriptor count (0x24) keeps bits 7:0.
  - Interrupt enable (0x2C) keeps bits 6:1.
  - Every other bit of these registers reads 0.
- R5: Writing channel control with bit 1 set starts a reset of that channel:
  - Bit 1 reads 1 for exactly RST_CYC (4) cycles after the write edge.
  - At the edge that ends this window, the on bit and the interrupt status of that channel become 0 and bit 1 reads 0. The direction and weight fields keep their values.
  - Writes to that channel's control word during the window are ignored.
- R6: Interrupt status (0x28) holds causes in bits 6:1, and bit 3 is descriptor complete.
  - A high `desc_done[n]` sets bit 3 of channel n.
  - Writing 1 to a bit clears it; writing 0 leaves it unchanged.
  - If a set and a clear of bit 3 fall in the same cycle, the set wins.
- R7: `irq` is high exactly when some channel n has bit n of the global enable (0xF4) set and a nonzero AND of its status and enable words.
- R8: Writing 0x10 with bit 0 set starts a global reset:
  - Bit 0 of 0x10 reads 1 for RST_CYC cycles.
  - Every write during that window is ignored.
  - At the end of the window, every register of the file returns to 0.
- R9: Poll control (0x14) keeps only bit 31 (polling enable) and bit 6 (divide-by-4 poll clock).
- R10: Port select (0x40) stores a 2-bit port number, and port control (0x44) reaches the selected port's word. Port control keeps bits 11:8 (endianness swap), bit 6 (drop on lost arbitration), bits 5:4 and bits 3:2 (burst lengths). The mask is 0x0F7C.
- R11: Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| desc_done | input | NCH | Stub descriptor-complete pulse, one per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a channel reset window with other traffic inside it. The stimulus arms a channel reset while that channel already has a pending status cause. It then issues a control write that lands mid-window, and samples the control word on every cycle of the window. This shows that the intruding write is dropped, that the cause is wiped at the closing edge, and that the direction and weight survive. A second hard case is a stub pulse in the same cycle as a write-1 acknowledge. The bench drives `desc_done` together with the write strobe to hit that edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [7:0] A_GCTL = 8'h10;
  localparam logic [7:0] A_POLL = 8'h14;
  localparam logic [7:0] A_CSEL = 8'h18;
  localparam logic [7:0] A_CCTL = 8'h1C;
  localparam logic [7:0] A_DBA  = 8'h20;
  localparam logic [7:0] A_DLEN = 8'h24;
  localparam logic [7:0] A_CIS  = 8'h28;
  localparam logic [7:0] A_CIE  = 8'h2C;
  localparam logic [7:0] A_PSEL = 8'h40;
  localparam logic [7:0] A_PCTL = 8'h44;
  localparam logic [7:0] A_GIE  = 8'hF4;

  localparam logic [31:0] M_POLL = 32'h8000_0040;
  localparam logic [31:0] M_PCTL = 32'h0000_0F7C;

  typedef struct packed {
    logic [1:0] weight;
    logic       tx;
    logic       on;
  } cctl_t;
endpackage

// File: rtl/dmac_rst_timer.sv
module dmac_rst_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr || done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC);
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_ctl,
  input  logic        wr_dba,
  input  logic        wr_dlen,
  input  logic        wr_cis,
  input  logic        wr_cie,
  input  logic [31:0] wdata,
  input  logic        done_in,
  output logic [31:0] ctl_rd,
  output logic [31:0] dba_q,
  output logic [31:0] dlen_rd,
  output logic [5:0]  cis_q,
  output logic [5:0]  cie_q,
  output logic        src,
  output logic        busy,
  output logic        on
);
  cctl_t            c;
  logic [CNT_W-1:0] dlen_q;
  logic [5:0]       cis_nxt;
  logic             rdone;

  dmac_rst_timer #(.CYC(RST_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .start(wr_ctl && wdata[1]),
    .busy (busy),
    .done (rdone)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c      <= '0;
      dba_q  <= '0;
      dlen_q <= '0;
      cie_q  <= '0;
    end else if (clr) begin
      c      <= '0;
      dba_q  <= '0;
      dlen_q <= '0;
      cie_q  <= '0;
    end else begin
      if (wr_ctl && !busy) c <= '{weight: wdata[17:16], tx: wdata[8], on: wdata[0]};
      else if (rdone)      c.on <= 1'b0;
      if (wr_dba)  dba_q  <= wdata;
      if (wr_dlen) dlen_q <= wdata[CNT_W-1:0];
      if (wr_cie)  cie_q  <= wdata[6:1];
    end
  end

  always_comb begin
    cis_nxt = cis_q;
    if (wr_cis)  cis_nxt = cis_nxt & ~wdata[6:1];
    if (done_in) cis_nxt[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cis_q <= '0;
    else if (clr || rdone)   cis_q <= '0;
    else                     cis_q <= cis_nxt;
  end

  assign ctl_rd  = {14'b0, c.weight, 7'b0, c.tx, 6'b0, busy, c.on};
  assign dlen_rd = 32'(dlen_q);
  assign src     = |(cis_q & cie_q);
  assign on      = c.on;
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_pkg::*;
#(
  parameter int NCH     = 20,
  parameter int NPORT   = 4,
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] desc_done,
  output logic           irq
);
  localparam int SEL_W  = $clog2(NCH);
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [SEL_W-1:0]            sel_q;
  logic [PSEL_W-1:0]           psel_q;
  logic [31:0]                 poll_q;
  logic [NCH-1:0]              gie_q;
  logic [NPORT-1:0][31:0]      pctl_q;
  logic                        gbusy, gdone, wr_ok, sel_ok, psel_ok;

  logic [NCH-1:0][31:0] ctl_rd_a, dba_a, dlen_a;
  logic [NCH-1:0][5:0]  cis_a, cie_a;
  logic [NCH-1:0]       src_a, ch_busy, ch_on;

  dmac_rst_timer #(.CYC(RST_CYC)) u_gtmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (1'b0),
    .start(bus_wr && (bus_addr == A_GCTL) && bus_wdata[0]),
    .busy (gbusy),
    .done (gdone)
  );

  assign wr_ok   = bus_wr && !gbusy;
  assign sel_ok  = 32'(sel_q) < NCH;
  assign psel_ok = 32'(psel_q) < NPORT;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = wr_ok && sel_ok && (sel_q == SEL_W'(n));
    dmac_chan #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (gdone),
      .wr_ctl (hit && (bus_addr == A_CCTL)),
      .wr_dba (hit && (bus_addr == A_DBA)),
      .wr_dlen(hit && (bus_addr == A_DLEN)),
      .wr_cis (hit && (bus_addr == A_CIS)),
      .wr_cie (hit && (bus_addr == A_CIE)),
      .wdata  (bus_wdata),
      .done_in(desc_done[n]),
      .ctl_rd (ctl_rd_a[n]),
      .dba_q  (dba_a[n]),
      .dlen_rd(dlen_a[n]),
      .cis_q  (cis_a[n]),
      .cie_q  (cie_a[n]),
      .src    (src_a[n]),
      .busy   (ch_busy[n]),
      .on     (ch_on[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      psel_q <= '0;
      poll_q <= '0;
      gie_q  <= '0;
      pctl_q <= '0;
    end else if (gdone) begin
      sel_q  <= '0;
      psel_q <= '0;
      poll_q <= '0;
      gie_q  <= '0;
      pctl_q <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_POLL: poll_q <= bus_wdata & M_POLL;
        A_CSEL: sel_q  <= bus_wdata[SEL_W-1:0];
        A_PSEL: psel_q <= bus_wdata[PSEL_W-1:0];
        A_PCTL: if (psel_ok) pctl_q[psel_q] <= bus_wdata & M_PCTL;
        A_GIE:  gie_q  <= bus_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GCTL: bus_rdata = {31'b0, gbusy};
      A_POLL: bus_rdata = poll_q;
      A_CSEL: bus_rdata = 32'(sel_q);
      A_CCTL: if (sel_ok) bus_rdata = ctl_rd_a[sel_q];
      A_DBA:  if (sel_ok) bus_rdata = dba_a[sel_q];
      A_DLEN: if (sel_ok) bus_rdata = dlen_a[sel_q];
      A_CIS:  if (sel_ok) bus_rdata = {25'b0, cis_a[sel_q], 1'b0};
      A_CIE:  if (sel_ok) bus_rdata = {25'b0, cie_a[sel_q], 1'b0};
      A_PSEL: bus_rdata = 32'(psel_q);
      A_PCTL: if (psel_ok) bus_rdata = pctl_q[psel_q];
      A_GIE:  bus_rdata = 32'(gie_q);
      default: ;
    endcase
  end

  assign irq = |(gie_q & src_a);
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk
  import dmac_pkg::*;
#(
  parameter int NCH     = 20,
  parameter int RST_CYC = 4,
  parameter int SEL_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [5:0]           wd_cause,
  input logic [SEL_W-1:0]     sel_q,
  input logic                 gbusy,
  input logic [NCH-1:0]       gie_q,
  input logic [NCH-1:0]       ch_busy,
  input logic [NCH-1:0]       ch_on,
  input logic [NCH-1:0][5:0]  cis_a,
  input logic [NCH-1:0][31:0] dba_a,
  input logic [NCH-1:0]       desc_done,
  input logic                 irq
);
  logic [7:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gcnt <= '0;
    else if (gbusy) gcnt <= gcnt + 8'd1;
    else            gcnt <= '0;
  end

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cis_a == '0) |-> !irq); // R7

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !gbusy && bus_addr == A_DBA && 32'(sel_q) >= NCH) |=> $stable(dba_a)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !gbusy && bus_addr == A_CIS && 32'(sel_q) < NCH && desc_done == '0)
      |=> ((cis_a[$past(sel_q)] & $past(wd_cause)) == '0)); // R6

  AST_GRST_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbusy) |-> (gie_q == '0 && sel_q == '0 && dba_a == '0)); // R8

  AST_GRST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    gbusy |-> (32'(gcnt) < RST_CYC)); // R8

  for (genvar n = 0; n < NCH; n++) begin : g_a
    AST_CRST_DROPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_busy[n]) |-> (!ch_on[n] && cis_a[n] == '0)); // R5
  end
endmodule

bind dmac_regbank dmac_regbank_chk #(.NCH(NCH), .RST_CYC(RST_CYC), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wd_cause (bus_wdata[6:1]),
  .sel_q    (sel_q),
  .gbusy    (gbusy),
  .gie_q    (gie_q),
  .ch_busy  (ch_busy),
  .ch_on    (ch_on),
  .cis_a    (cis_a),
  .dba_a    (dba_a),
  .desc_done(desc_done),
  .irq      (irq)
);

// File: tb/sim_dmac_regbank.sv
module sim_dmac_regbank;
  localparam int CLK_NS  = 10;
  localparam int NCH     = 20;
  localparam int NPORT   = 4;
  localparam int RST_CYC = 4;

  localparam logic [7:0] GCTL = 8'h10, POLL = 8'h14, CSEL = 8'h18, CCTL = 8'h1C,
                         DBA = 8'h20, DLEN = 8'h24, CIS = 8'h28, CIE = 8'h2C,
                         PSEL = 8'h40, PCTL = 8'h44, GIE = 8'hF4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] desc_done = '0;
  logic           irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2) clk = ~clk;

  dmac_regbank #(.NCH(NCH), .NPORT(NPORT), .CNT_W(8), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .desc_done(desc_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chkrd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    desc_done[n] = 1'b1;
    @(negedge clk);
    desc_done = '0;
  endtask

  function automatic logic [31:0] ctl_exp(input int n);
    return (32'(n & 3) << 16) | (32'(n & 1) << 8) | 32'((n >> 1) & 1);
  endfunction

  function automatic logic [31:0] dba_val(input int n);
    return 32'hA500_0000 + 32'(n) * 32'h0001_0111;
  endfunction

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chkrd("R1", GCTL, 0); chkrd("R1", POLL, 0); chkrd("R1", CSEL, 0);
    chkrd("R1", CCTL, 0); chkrd("R1", DBA, 0);  chkrd("R1", DLEN, 0);
    chkrd("R1", CIS, 0);  chkrd("R1", CIE, 0);  chkrd("R1", PSEL, 0);
    chkrd("R1", PCTL, 0); chkrd("R1", GIE, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 R4 fill every bank with distinct values, junk in unused bits
    for (int n = 0; n < NCH; n++) begin
      wr(CSEL, 32'(n));
      wr(CCTL, ctl_exp(n) | 32'hFFFC_FEFC);
      wr(DBA, dba_val(n));
      wr(DLEN, 32'h0000_3400 | 32'(n + 3));
      wr(CIE, 32'(n * 6) | 32'h8000_0081);
    end

    // R3 out-of-range select
    for (int s = NCH; s < 32; s++) begin
      wr(CSEL, 32'(s));
      chkrd("R3 sel readback", CSEL, 32'(s));
      wr(DBA, 32'hDEAD_BEEF);
      wr(CCTL, 32'h0000_0001);
      chkrd("R3 dba", DBA, 0);
      chkrd("R3 ctl", CCTL, 0);
    end

    for (int n = 0; n < NCH; n++) begin
      wr(CSEL, 32'(n));
      chkrd("R4 ctl", CCTL, ctl_exp(n));
      chkrd("R2 dba", DBA, dba_val(n));
      chkrd("R4 dlen", DLEN, 32'(n + 3));
      chkrd("R4 cie", CIE, 32'(n * 6) & 32'h7E);
      chkrd("R2 cis", CIS, 0);
    end

    // R5 channel reset timing, with pending status
    wr(CSEL, 7);
    pulse(7);
    chkrd("R6 set", CIS, 32'h08);
    wr(CCTL, 32'h0001_0103);
    for (int k = 0; k < RST_CYC; k++) begin
      chkrd("R5 pending", CCTL, 32'h0001_0103);
      @(negedge clk);
    end
    chkrd("R5 done", CCTL, 32'h0001_0100);
    chkrd("R5 status cleared", CIS, 0);
    wr(CSEL, 6);
    chkrd("R5 neighbour", CCTL, ctl_exp(6));
    wr(CSEL, 7);
    wr(CCTL, 32'h0000_0003);
    wr(CCTL, 32'h0003_0101);
    repeat (RST_CYC) @(negedge clk);
    chkrd("R5 write ignored", CCTL, 0);

    // R6 write-1-to-clear and same-cycle set
    wr(CSEL, 3);
    pulse(3);
    chkrd("R6 set", CIS, 32'h08);
    wr(CIS, 32'h0000_0074);
    chkrd("R6 w0 keeps", CIS, 32'h08);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = CIS; bus_wdata = 32'h08; desc_done[3] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; desc_done = '0;
    chkrd("R6 set wins", CIS, 32'h08);
    wr(CIS, 32'h7E);
    chkrd("R6 cleared", CIS, 0);

    // R7 interrupt sweep
    for (int n = 0; n < NCH; n++) begin
      wr(CSEL, 32'(n));
      wr(CIE, 32'h08);
      pulse(n);
      wr(GIE, 32'(1) << n);
      #1; chk("R7 enabled", 32'(irq), 1);
      wr(GIE, ~(32'(1) << n) & 32'h000F_FFFF);
      #1; chk("R7 masked", 32'(irq), 0);
      wr(GIE, 32'h000F_FFFF);
      wr(CIE, 32'h0);
      #1; chk("R7 cause disabled", 32'(irq), 0);
      wr(CIS, 32'h7E);
    end
    wr(GIE, 0);

    // R9 poll control
    wr(POLL, 32'hFFFF_FFFF);
    chkrd("R9", POLL, 32'h8000_0040);

    // R10 port banks
    for (int p = 0; p < NPORT; p++) begin
      wr(PSEL, 32'(p));
      wr(PCTL, 32'hFFFF_F083 ^ (32'(p) * 32'h0000_0A5C));
    end
    for (int p = 0; p < NPORT; p++) begin
      wr(PSEL, 32'(p));
      chkrd("R10 psel", PSEL, 32'(p));
      chkrd("R10 pctl", PCTL, (32'hFFFF_F083 ^ (32'(p) * 32'h0000_0A5C)) & 32'h0F7C);
    end

    // R11 unmapped
    chkrd("R11", 8'h00, 0); chkrd("R11", 8'h30, 0); chkrd("R11", 8'hFC, 0);

    // R8 global reset
    wr(GIE, 32'h000A_BCDE);
    wr(CSEL, 5);
    wr(GCTL, 32'h1);
    chkrd("R8 busy", GCTL, 1);
    wr(GIE, 32'h000F_FFFF);
    chkrd("R8 write ignored", GIE, 32'h000A_BCDE);
    repeat (RST_CYC) @(negedge clk);
    chkrd("R8 gctl", GCTL, 0); chkrd("R8 gie", GIE, 0); chkrd("R8 sel", CSEL, 0);
    chkrd("R8 poll", POLL, 0); chkrd("R8 pctl", PCTL, 0); chkrd("R8 dba", DBA, 0);
    chkrd("R8 ctl", CCTL, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule